// File: doc/BRIEF.md
# Cascaded Interrupt Trigger Front End

This block sits in front of a pair of cascaded interrupt controllers, one primary and one secondary, each with eight request levels. It samples sixteen interrupt lines and turns their activity into one-cycle set and clear strobes for the request bits of each controller. Lines 0 to 7 belong to the primary and lines 8 to 15 to the secondary. Each line is edge or level triggered, as chosen by one trigger-select register per controller. Some system lines can never be made level triggered, whatever software writes to these registers.

The block also joins the two controllers. When the secondary reports an eligible pending level, the block sends one pulse into the primary's level 2 and then stays quiet until that request is acknowledged. In the same way, a pending primary raises one interrupt pulse toward the processor per acknowledge. An acknowledge carries a vector. The block decodes it into acknowledge strobes and level numbers for one or both controllers. Priority resolution, masking and in-service tracking live in the controllers, not here.

Top module: `irq_trigger_front`

## Requirements
- R1: After reset both trigger-select registers read 0, so every line is edge triggered, and all strobes and pulses are low.
- R2: A write to the primary trigger-select register (`ctl_sel`=0) stores the data ANDed with 0xF8, so primary lines 0, 1 and 2 stay edge triggered. A line with its select bit set to 1 is level triggered; a bit at 0 means edge.
- R3: A write to the secondary trigger-select register (`ctl_sel`=1) stores the data ANDed with 0xDE, so secondary levels 0 and 5 (lines 8 and 13) stay edge triggered.
- R4: A rise on an edge-triggered line gives exactly one set strobe on that level, in the cycle after the clock edge that first samples the line high. The line's fall gives no clear strobe.
- R5: A level-triggered line gives a set strobe in every cycle while its sample is high. When it falls it gives exactly one clear strobe, in the cycle after the edge that first samples it low.
- R6: While a controller's ready input is low, its set and clear strobes stay low whatever its lines do.
- R7: When the secondary is pending and not yet raised, `cascade_pulse` goes high for one cycle, together with primary set strobe bit 2. No further pulse follows until an acknowledge routed to the secondary.
- R8: When the primary is pending and not yet raised, `cpu_intr` goes high for one cycle. No further pulse follows until an acknowledge.
- R9: An acknowledge whose vector bits [7:3] equal `slave_base` asserts `ack_s` with level `ack_vector[2:0]`, and also `ack_m` with level 2.
- R10: Any other acknowledge asserts only `ack_m`, with level `ack_vector[2:0]`.
- R11: An acknowledge clears the raised state of each controller it reaches. If that controller is still pending, it pulses again two cycles after the acknowledge is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 16 | Interrupt lines; [7:0] primary, [15:8] secondary |
| ready_m | input | 1 | Primary controller has finished initialization |
| ready_s | input | 1 | Secondary controller has finished initialization |
| ctl_sel | input | 1 | Trigger-select register select: 0 primary, 1 secondary |
| ctl_wr | input | 1 | Write strobe for the selected trigger-select register |
| ctl_wdata | input | 8 | Write data |
| ctl_rdata | output | 8 | Stored value of the selected register |
| pend_m | input | 1 | Primary has an eligible pending level |
| pend_s | input | 1 | Secondary has an eligible pending level |
| ack_valid | input | 1 | Acknowledge presented this cycle |
| ack_vector | input | 8 | Vector being acknowledged |
| slave_base | input | 5 | Upper vector bits of the secondary's vector base |
| req_set_m | output | 8 | Primary request-set strobes |
| req_clr_m | output | 8 | Primary request-clear strobes |
| req_set_s | output | 8 | Secondary request-set strobes |
| req_clr_s | output | 8 | Secondary request-clear strobes |
| cascade_pulse | output | 1 | One-cycle secondary-to-primary signal |
| cpu_intr | output | 1 | One-cycle interrupt pulse toward the processor |
| ack_m | output | 1 | Acknowledge for the primary |
| ack_lvl_m | output | 3 | Level acknowledged on the primary |
| ack_s | output | 1 | Acknowledge for the secondary |
| ack_lvl_s | output | 3 | Level acknowledged on the secondary |

## Verification
The same line is driven high and then low in edge mode and in level mode. This shows a one-cycle set pulse with a silent fall apart from a set that lasts as long as the line is high followed by a single clear. The protected lines 1 and 13 are given an all-ones select write and still behave as edges, which separates the forced masks from a plain register. Pending inputs are held high across several cycles, before and after an acknowledge, so a design that pulses once per pending cycle or never re-arms is told apart from a correct one. Acknowledge vectors that match and miss the secondary base separate dual routing from primary-only routing.

// File: rtl/irq_fe_pkg.sv
// Shared constants for the cascaded trigger front end.
// Assumes eight levels per controller and an 8-bit vector.
package irq_fe_pkg;
    localparam int LINES      = 8;
    localparam int LVL_W      = $clog2(LINES);
    localparam int VEC_W      = 8;
    localparam int BASE_W     = VEC_W - LVL_W;
    localparam int CASC_LEVEL = 2;
    localparam logic [LINES-1:0] PRI_LVL_ALLOW = 8'hF8;
    localparam logic [LINES-1:0] SEC_LVL_ALLOW = 8'hDE;
    typedef enum logic {SEL_PRI = 1'b0, SEL_SEC = 1'b1} ctl_sel_e;
endpackage

// File: rtl/trig_lane_bank.sv
// One controller's worth of line sampling and trigger-mode decode.
// Holds the trigger-select register (masked by ALLOW on write), samples
// the lines twice, and emits set/clear strobes gated by ready.
// Assumes extra_set is itself a one-cycle event (edge semantics).
module trig_lane_bank #(
    parameter int N = 8,
    parameter logic [N-1:0] ALLOW = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    input  logic         ready,
    input  logic         wr_en,
    input  logic [N-1:0] wr_data,
    input  logic [N-1:0] extra_set,
    output logic [N-1:0] ctl_q,
    output logic [N-1:0] set_o,
    output logic [N-1:0] clr_o
);
    logic [N-1:0] samp_now;
    logic [N-1:0] samp_old;

    // Trigger-select register: forced-edge bits never stored as level.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctl_q <= '0;
        else if (wr_en) ctl_q <= wr_data & ALLOW;
    end

    // Two-stage sample of the lines for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_now <= '0;
            samp_old <= '0;
        end else begin
            samp_now <= lines;
            samp_old <= samp_now;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic hit;
        // Per-lane request event: level follows the sample, edge takes the rise.
        always_comb begin
            hit      = ctl_q[i] ? samp_now[i] : (samp_now[i] & ~samp_old[i]);
            set_o[i] = ready & (hit | extra_set[i]);
            clr_o[i] = ready & ctl_q[i] & samp_old[i] & ~samp_now[i];
        end
    end
endmodule

// File: rtl/raise_once.sv
// Single-shot signaller: pulses once when pending, then holds off
// until an acknowledge re-arms it. Assumes pend is a steady level.
module raise_once (
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    input  logic pend,
    input  logic ack,
    output logic pulse
);
    logic raised;

    // Raised flag and its one-cycle announcement pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raised <= 1'b0;
            pulse  <= 1'b0;
        end else if (ready && pend && !raised) begin
            raised <= 1'b1;
            pulse  <= 1'b1;
        end else begin
            pulse <= 1'b0;
            if (ack) raised <= 1'b0;
        end
    end
endmodule

// File: rtl/ack_route.sv
// Decodes an acknowledge vector into per-controller strobes and levels.
// A vector in the secondary's range also acknowledges the cascade level.
module ack_route
    import irq_fe_pkg::*;
(
    input  logic              ack_valid,
    input  logic [VEC_W-1:0]  vector,
    input  logic [BASE_W-1:0] sec_base,
    output logic              ack_m,
    output logic [LVL_W-1:0]  lvl_m,
    output logic              ack_s,
    output logic [LVL_W-1:0]  lvl_s
);
    logic from_sec;

    // Routing decode: secondary hit, cascade level substituted on primary.
    always_comb begin
        from_sec = (vector[VEC_W-1:LVL_W] == sec_base);
        ack_s    = ack_valid & from_sec;
        ack_m    = ack_valid;
        lvl_s    = vector[LVL_W-1:0];
        lvl_m    = from_sec ? LVL_W'(CASC_LEVEL) : vector[LVL_W-1:0];
    end
endmodule

// File: rtl/irq_trigger_front.sv
// Top of the cascaded trigger front end: two lane banks, two single-shot
// signallers and the acknowledge decoder. The secondary's signal is fed
// into the primary's cascade level as an edge event.
module irq_trigger_front
    import irq_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*LINES-1:0] irq_lines,
    input  logic              ready_m,
    input  logic              ready_s,
    input  logic              ctl_sel,
    input  logic              ctl_wr,
    input  logic [LINES-1:0]  ctl_wdata,
    output logic [LINES-1:0]  ctl_rdata,
    input  logic              pend_m,
    input  logic              pend_s,
    input  logic              ack_valid,
    input  logic [VEC_W-1:0]  ack_vector,
    input  logic [BASE_W-1:0] slave_base,
    output logic [LINES-1:0]  req_set_m,
    output logic [LINES-1:0]  req_clr_m,
    output logic [LINES-1:0]  req_set_s,
    output logic [LINES-1:0]  req_clr_s,
    output logic              cascade_pulse,
    output logic              cpu_intr,
    output logic              ack_m,
    output logic [LVL_W-1:0]  ack_lvl_m,
    output logic              ack_s,
    output logic [LVL_W-1:0]  ack_lvl_s
);
    logic [LINES-1:0] ctl_m_q, ctl_s_q, casc_inject;
    logic             wr_m, wr_s;

    // Write steering and read-back of the selected register.
    always_comb begin
        wr_m        = ctl_wr & (ctl_sel == SEL_PRI);
        wr_s        = ctl_wr & (ctl_sel == SEL_SEC);
        ctl_rdata   = (ctl_sel == SEL_SEC) ? ctl_s_q : ctl_m_q;
        casc_inject = '0;
        casc_inject[CASC_LEVEL] = cascade_pulse;
    end

    trig_lane_bank #(.N(LINES), .ALLOW(PRI_LVL_ALLOW)) i_bank_m (
        .clk(clk), .rst_n(rst_n), .lines(irq_lines[LINES-1:0]), .ready(ready_m),
        .wr_en(wr_m), .wr_data(ctl_wdata), .extra_set(casc_inject),
        .ctl_q(ctl_m_q), .set_o(req_set_m), .clr_o(req_clr_m)
    );

    trig_lane_bank #(.N(LINES), .ALLOW(SEC_LVL_ALLOW)) i_bank_s (
        .clk(clk), .rst_n(rst_n), .lines(irq_lines[2*LINES-1:LINES]), .ready(ready_s),
        .wr_en(wr_s), .wr_data(ctl_wdata), .extra_set('0),
        .ctl_q(ctl_s_q), .set_o(req_set_s), .clr_o(req_clr_s)
    );

    raise_once i_raise_s (
        .clk(clk), .rst_n(rst_n), .ready(ready_s), .pend(pend_s),
        .ack(ack_s), .pulse(cascade_pulse)
    );

    raise_once i_raise_m (
        .clk(clk), .rst_n(rst_n), .ready(ready_m), .pend(pend_m),
        .ack(ack_m), .pulse(cpu_intr)
    );

    ack_route i_ack (
        .ack_valid(ack_valid), .vector(ack_vector), .sec_base(slave_base),
        .ack_m(ack_m), .lvl_m(ack_lvl_m), .ack_s(ack_s), .lvl_s(ack_lvl_s)
    );
endmodule

// File: rtl/irq_front_chk.sv
// Property checker for irq_trigger_front, bound to every instance.
module irq_front_chk
    import irq_fe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ready_s,
    input logic              ctl_sel,
    input logic [LINES-1:0]  ctl_rdata,
    input logic [LINES-1:0]  req_set_s,
    input logic [LINES-1:0]  req_clr_m,
    input logic [LINES-1:0]  req_clr_s,
    input logic              cascade_pulse,
    input logic              cpu_intr,
    input logic              ack_m,
    input logic [LVL_W-1:0]  ack_lvl_m,
    input logic              ack_s
);
    p_pri_forced_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_clr_m[2:0] == 3'b000) && (ctl_sel || ctl_rdata[2:0] == 3'b000));

    p_sec_forced_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_clr_s & 8'h21) == 8'h00) && (!ctl_sel || (ctl_rdata & 8'h21) == 8'h00));

    p_not_ready_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_s |-> (req_set_s == 8'h00 && req_clr_s == 8'h00));

    p_cascade_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_pulse |=> !cascade_pulse);

    p_cpu_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_intr |=> !cpu_intr);

    p_sec_ack_dual_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_s |-> (ack_m && ack_lvl_m == LVL_W'(CASC_LEVEL)));
endmodule

bind irq_trigger_front irq_front_chk i_chk (
    .clk(clk), .rst_n(rst_n), .ready_s(ready_s), .ctl_sel(ctl_sel),
    .ctl_rdata(ctl_rdata), .req_set_s(req_set_s), .req_clr_m(req_clr_m),
    .req_clr_s(req_clr_s), .cascade_pulse(cascade_pulse), .cpu_intr(cpu_intr),
    .ack_m(ack_m), .ack_lvl_m(ack_lvl_m), .ack_s(ack_s)
);

// File: tb/test_irq_trigger_front.sv
// Directed bench: one task per scenario, inputs driven at the falling edge,
// outputs sampled at the falling edge after the rising edge of interest.
module test_irq_trigger_front;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] irq_lines;
    logic        ready_m, ready_s, ctl_sel, ctl_wr, pend_m, pend_s, ack_valid;
    logic [7:0]  ctl_wdata, ctl_rdata, ack_vector;
    logic [4:0]  slave_base;
    logic [7:0]  req_set_m, req_clr_m, req_set_s, req_clr_s;
    logic        cascade_pulse, cpu_intr, ack_m, ack_s;
    logic [2:0]  ack_lvl_m, ack_lvl_s;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    irq_trigger_front i_irq_trigger_front (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .ready_m(ready_m),
        .ready_s(ready_s), .ctl_sel(ctl_sel), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .pend_m(pend_m), .pend_s(pend_s), .ack_valid(ack_valid),
        .ack_vector(ack_vector), .slave_base(slave_base), .req_set_m(req_set_m),
        .req_clr_m(req_clr_m), .req_set_s(req_set_s), .req_clr_s(req_clr_s),
        .cascade_pulse(cascade_pulse), .cpu_intr(cpu_intr), .ack_m(ack_m),
        .ack_lvl_m(ack_lvl_m), .ack_s(ack_s), .ack_lvl_s(ack_lvl_s)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_ctl(input logic sel, input logic [7:0] d);
        ctl_sel = sel; ctl_wr = 1'b1; ctl_wdata = d;
        tick();
        ctl_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 set_m", req_set_m, 0);
        check("R1 cascade/cpu", {cascade_pulse, cpu_intr}, 0);
        ctl_sel = 1'b0; #1; check("R1 pri sel reg", ctl_rdata, 0);
        ctl_sel = 1'b1; #1; check("R1 sec sel reg", ctl_rdata, 0);
    endtask

    task automatic t_masks();
        wr_ctl(1'b0, 8'hFF); #1; check("R2 pri readback", ctl_rdata, 8'hF8);
        wr_ctl(1'b1, 8'hFF); #1; check("R3 sec readback", ctl_rdata, 8'hDE);
        wr_ctl(1'b0, 8'h00); wr_ctl(1'b1, 8'h00);
    endtask

    task automatic t_edge();
        irq_lines[4] = 1'b1; irq_lines[11] = 1'b1;
        tick();
        check("R4 edge set_m", req_set_m, 8'h10);
        check("R4 edge set_s", req_set_s, 8'h08);
        tick();
        check("R4 edge one cycle", {req_set_m, req_set_s}, 0);
        irq_lines[4] = 1'b0; irq_lines[11] = 1'b0;
        tick();
        check("R4 no clear on fall", {req_clr_m, req_clr_s}, 0);
        tick();
        check("R4 quiet after fall", {req_set_m, req_clr_m}, 0);
    endtask

    task automatic t_level();
        wr_ctl(1'b0, 8'h10);
        irq_lines[4] = 1'b1;
        tick(); check("R5 level set c1", req_set_m, 8'h10);
        tick(); check("R5 level set c2", req_set_m, 8'h10);
        irq_lines[4] = 1'b0;
        tick(); check("R5 level clr", {req_set_m, req_clr_m}, 16'h0010);
        tick(); check("R5 clr one cycle", req_clr_m, 0);
        wr_ctl(1'b0, 8'hFF); wr_ctl(1'b1, 8'hFF);
        irq_lines[1] = 1'b1; irq_lines[13] = 1'b1;
        tick(); check("R2 line1 set", req_set_m, 8'h02);
        check("R3 line13 set", req_set_s, 8'h20);
        tick(); check("R2 line1 edge only", req_set_m, 0);
        check("R3 line13 edge only", req_set_s, 0);
        irq_lines[1] = 1'b0; irq_lines[13] = 1'b0;
        tick(); check("R2 R3 no clear", {req_clr_m, req_clr_s}, 0);
        wr_ctl(1'b0, 8'h00); wr_ctl(1'b1, 8'h00);
    endtask

    task automatic t_not_ready();
        wr_ctl(1'b1, 8'h02);
        ready_s = 1'b0;
        irq_lines[9] = 1'b1;
        tick(); check("R6 no set", req_set_s, 0);
        tick(); check("R6 no set held", req_set_s, 0);
        irq_lines[9] = 1'b0;
        tick(); check("R6 no clr", req_clr_s, 0);
        tick();
        ready_s = 1'b1;
        wr_ctl(1'b1, 8'h00);
    endtask

    task automatic t_cascade();
        slave_base = 5'b01110;
        pend_s = 1'b1;
        tick(); check("R7 cascade pulse", {cascade_pulse, req_set_m}, 9'h104);
        tick(); check("R7 pulse ends", {cascade_pulse, req_set_m}, 0);
        tick(); check("R7 held off", cascade_pulse, 0);
        ack_valid = 1'b1; ack_vector = {5'b01110, 3'd6};
        #1;
        check("R9 sec routing", {ack_s, ack_lvl_s, ack_m, ack_lvl_m}, {1'b1, 3'd6, 1'b1, 3'd2});
        tick(); ack_valid = 1'b0;
        check("R11 no pulse yet", cascade_pulse, 0);
        tick(); check("R11 re-signal", cascade_pulse, 1);
        pend_s = 1'b0;
        tick(); check("R7 single again", cascade_pulse, 0);
    endtask

    task automatic t_cpu();
        pend_m = 1'b1;
        tick(); check("R8 cpu pulse", cpu_intr, 1);
        tick(); check("R8 pulse ends", cpu_intr, 0);
        tick(); check("R8 held off", cpu_intr, 0);
        ack_valid = 1'b1; ack_vector = 8'h23;
        #1;
        check("R10 pri routing", {ack_s, ack_m, ack_lvl_m}, {1'b0, 1'b1, 3'd3});
        tick(); ack_valid = 1'b0;
        check("R11 cpu wait", cpu_intr, 0);
        tick(); check("R11 cpu re-signal", cpu_intr, 1);
        pend_m = 1'b0;
        tick();
    endtask

    initial begin
        rst_n = 1'b0; irq_lines = '0; ready_m = 1'b0; ready_s = 1'b0;
        ctl_sel = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; pend_m = 1'b0; pend_s = 1'b0;
        ack_valid = 1'b0; ack_vector = '0; slave_base = 5'b01110;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        ready_m = 1'b1; ready_s = 1'b1;
        t_masks();
        t_edge();
        t_level();
        t_not_ready();
        t_cascade();
        t_cpu();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule